// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a virtual address into a physical address through a per-process segment table held in an internal register array. The upper bits of the virtual address pick a segment and the lower bits give an offset into it. Two small registers, a table start index and a table entry count, place the active table inside the array and limit it, so one array can hold tables for several processes and a context switch rewrites only those two registers.

Each request runs through four checks in a fixed order. The first is the segment range, then the entry's valid bit, then the offset against the segment bound, and last the requested access against the entry's permissions. The first check that fails sets a fault code. If all four pass, the physical address is the segment base plus the offset.

Requests enter on a valid/ready stream. A request is accepted on any edge where `req_valid` and `req_ready` are both high. Its result is registered at that edge and shown on `resp_valid` one cycle later. While `resp_ready` is low, the result stays on the outputs unchanged and `req_ready` drops, so no new request is taken. The table and its two registers are written through plain write-enable pins with no handshake.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_vaddr[VA_W-1 -: SEG_W]` and the offset is `req_vaddr[OFF_W-1:0]`.
- R2: The table entry used is `(table start + segment number) mod TBL_DEPTH`.
- R3: If the segment number is greater than or equal to the table entry count, the fault code is 1 (range). This check has the highest priority.
- R4: Otherwise, if the selected entry's valid bit is 0, the fault code is 2 (invalid), whatever the offset and the access are.
- R5: Otherwise, if the offset is greater than or equal to the entry's bound, the fault code is 3 (bound), whatever the access is.
- R6: Otherwise, the access code is checked against the permission bits. Access 0 (read) needs perm bit 0, access 1 (write) needs perm bit 1 and access 2 (execute) needs perm bit 2. Access 3 is reserved and is never permitted. A failed check gives fault code 4 (permission).
- R7: When all checks pass, the fault code is 0 and `resp_paddr` = (entry base + offset) mod 2^PA_W. On any fault, `resp_paddr` is 0.
- R8: The result of a request accepted at an edge appears with `resp_valid` high after that edge. While `resp_valid` is high and `resp_ready` is low, the result holds stable and `req_ready` is low. `resp_valid` falls once the result is taken and no new request is accepted.
- R9: An entry write or a table-register write made on the same edge that accepts a lookup does not affect that lookup, which uses the old values. The next lookup sees the new values.
- R10: After reset, `resp_valid` is 0, `req_ready` is 1, every entry is invalid, and the table start and entry count are 0, so every request gets a range fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_base_we | input | 1 | Write enable for the table start index |
| tbl_base_in | input | IDX_W | New table start index |
| tbl_size_we | input | 1 | Write enable for the table entry count |
| tbl_size_in | input | IDX_W+1 | New table entry count |
| cfg_we | input | 1 | Write enable for one table entry |
| cfg_idx | input | IDX_W | Array index of the entry to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_base | input | PA_W | Segment physical base to store |
| cfg_bound | input | OFF_W+1 | Segment size in bytes to store |
| cfg_perm | input | 3 | Permissions to store: bit0 read, bit1 write, bit2 execute |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_access | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_fault | output | 3 | 0 ok, 1 range, 2 invalid, 3 bound, 4 permission |
| resp_paddr | output | PA_W | Physical address, 0 on a fault |

## Verification
Requests are built so that each one fails exactly one check, and the exact fault code shows which check fired. Other requests fail several checks at once (an invalid entry with an oversized offset and a forbidden access, or an out-of-bound offset with a forbidden access), so the priority order is what decides the code. Successful lookups use offsets one below the bound and a base near the top of the physical space, to test the bound edge and the wrap of the addition. A nonzero table start that wraps around the array, a table write on the same edge as a lookup, and a stalled consumer with a second request waiting test the indexing, the read-before-write ordering and the back-pressure rules.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_BOUND   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int PA_W      = 20,
  parameter int BND_W     = 13,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [BND_W-1:0]  wr_bound,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [PA_W-1:0]   rd_base,
  output logic [BND_W-1:0]  rd_bound,
  output logic [PERM_W-1:0] rd_perm
);

  localparam int ENT_W = 1 + PA_W + BND_W + PERM_W;

  logic [ENT_W-1:0] ent_all [TBL_DEPTH];
  logic [ENT_W-1:0] wr_word;

  assign wr_word = {wr_valid, wr_base, wr_bound, wr_perm};

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ent_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))      ent_q <= wr_word;
    end
    assign ent_all[g] = ent_q;
  end

  assign {rd_valid, rd_base, rd_bound, rd_perm} = ent_all[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_all[$past(wr_idx)] == $past(wr_word)));  // R9

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 20,
  parameter int SIZE_W = 5,
  localparam int BND_W = OFF_W + 1,
  localparam int CMP_W = ((SEG_W > SIZE_W) ? SEG_W : SIZE_W) + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] tbl_size,
  input  logic              ent_valid,
  input  logic [PA_W-1:0]   ent_base,
  input  logic [BND_W-1:0]  ent_bound,
  input  logic [PERM_W-1:0] ent_perm,
  input  logic [1:0]        access,
  output fault_e            fault,
  output logic [PA_W-1:0]   paddr
);

  logic in_range, in_bound, allowed;

  assign in_range = CMP_W'(seg) < CMP_W'(tbl_size);
  assign in_bound = BND_W'(off) < ent_bound;

  always_comb begin
    unique case (access_e'(access))
      ACC_READ:  allowed = ent_perm[0];
      ACC_WRITE: allowed = ent_perm[1];
      ACC_EXEC:  allowed = ent_perm[2];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!in_range)       fault = FLT_RANGE;
    else if (!ent_valid) fault = FLT_INVALID;
    else if (!in_bound)  fault = FLT_BOUND;
    else if (!allowed)   fault = FLT_PERM;
    else                 paddr = ent_base + PA_W'(off);
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_W     = 4,
  parameter int PA_W      = 20,
  parameter int TBL_DEPTH = 16,
  localparam int OFF_W    = VA_W - SEG_W,
  localparam int BND_W    = OFF_W + 1,
  localparam int IDX_W    = $clog2(TBL_DEPTH),
  localparam int SIZE_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_base_we,
  input  logic [IDX_W-1:0]  tbl_base_in,
  input  logic              tbl_size_we,
  input  logic [SIZE_W-1:0] tbl_size_in,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [BND_W-1:0]  cfg_bound,
  input  logic [2:0]        cfg_perm,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_access,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [2:0]        resp_fault,
  output logic [PA_W-1:0]   resp_paddr
);

  logic [IDX_W-1:0]  tbl_base_q;
  logic [SIZE_W-1:0] tbl_size_q;
  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  ent_idx;
  logic              ent_valid;
  logic [PA_W-1:0]   ent_base;
  logic [BND_W-1:0]  ent_bound;
  logic [PERM_W-1:0] ent_perm;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_paddr;
  logic              accept;
  logic              rv_q;
  fault_e            fault_q;
  logic [PA_W-1:0]   paddr_q;

  assign seg     = req_vaddr[VA_W-1 -: SEG_W];
  assign off     = req_vaddr[OFF_W-1:0];
  assign ent_idx = tbl_base_q + IDX_W'(seg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q <= '0;
      tbl_size_q <= '0;
    end else begin
      if (tbl_base_we) tbl_base_q <= tbl_base_in;
      if (tbl_size_we) tbl_size_q <= tbl_size_in;
    end
  end

  seg_table #(
    .TBL_DEPTH(TBL_DEPTH), .PA_W(PA_W), .BND_W(BND_W)
  ) i_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_base(cfg_base), .wr_bound(cfg_bound), .wr_perm(cfg_perm),
    .rd_idx(ent_idx), .rd_valid(ent_valid), .rd_base(ent_base),
    .rd_bound(ent_bound), .rd_perm(ent_perm)
  );

  seg_check #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SIZE_W(SIZE_W)
  ) i_check (
    .seg(seg), .off(off), .tbl_size(tbl_size_q),
    .ent_valid(ent_valid), .ent_base(ent_base), .ent_bound(ent_bound),
    .ent_perm(ent_perm), .access(req_access),
    .fault(chk_fault), .paddr(chk_paddr)
  );

  assign req_ready = !rv_q || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (accept) begin
      rv_q    <= 1'b1;
      fault_q <= chk_fault;
      paddr_q <= chk_paddr;
    end else if (resp_ready) begin
      rv_q    <= 1'b0;
    end
  end

  assign resp_valid = rv_q;
  assign resp_fault = fault_q;
  assign resp_paddr = paddr_q;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);  // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_fault) && $stable(resp_paddr)));  // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);  // R8

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 3'd0) |-> (resp_paddr == '0));  // R7

  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault <= 3'd4));  // R3

  AST_EMPTY_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tbl_size_q == '0) |=> (resp_fault == 3'd1));  // R10

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 16, SEG_W = 4, PA_W = 20, TBL_DEPTH = 16;
  localparam int OFF_W = VA_W - SEG_W, BND_W = OFF_W + 1, IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic tbl_base_we = 0, tbl_size_we = 0, cfg_we = 0, cfg_valid = 0;
  logic [IDX_W-1:0] tbl_base_in = 0, cfg_idx = 0;
  logic [IDX_W:0] tbl_size_in = 0;
  logic [PA_W-1:0] cfg_base = 0;
  logic [BND_W-1:0] cfg_bound = 0;
  logic [2:0] cfg_perm = 0;
  logic req_valid = 0, resp_ready = 1;
  logic [VA_W-1:0] req_vaddr = 0;
  logic [1:0] req_access = 0;
  logic req_ready, resp_valid;
  logic [2:0] resp_fault;
  logic [PA_W-1:0] resp_paddr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate i_seg_xlate (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_entry(int idx, bit v, int base, int bound, int perm);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_base = PA_W'(base); cfg_bound = BND_W'(bound); cfg_perm = 3'(perm);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_table(int base, int size);
    @(negedge clk);
    tbl_base_we = 1; tbl_base_in = IDX_W'(base);
    tbl_size_we = 1; tbl_size_in = (IDX_W+1)'(size);
    @(negedge clk);
    tbl_base_we = 0; tbl_size_we = 0;
  endtask

  function automatic logic [VA_W-1:0] va(int seg, int off);
    return {SEG_W'(seg), OFF_W'(off)};
  endfunction

  task automatic lookup(string tag, logic [VA_W-1:0] a, int acc, int ef, int ep);
    @(negedge clk);
    req_valid = 1; req_vaddr = a; req_access = 2'(acc);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, 32'(resp_valid), 1);
    chk({tag, " fault"}, 32'(resp_fault), 32'(ef));
    chk({tag, " paddr"}, 32'(resp_paddr), 32'(ep));
  endtask

  task automatic t_reset;
    chk("R10 resp_valid", 32'(resp_valid), 0);
    chk("R10 req_ready", 32'(req_ready), 1);
    lookup("R10 empty table", va(0, 0), 0, 1, 0);
  endtask

  task automatic t_basic;
    set_table(0, 4);
    put_entry(0, 1, 'h10000, 'h100, 3'b001);
    put_entry(1, 0, 'h20000, 'h1000, 3'b111);
    put_entry(2, 1, 'hFFF00, 'h1000, 3'b111);
    put_entry(3, 1, 'h30000, 'h20, 3'b010);
    put_entry(5, 1, 'h50000, 'h1000, 3'b111);
    lookup("R1 R7 ok read", va(0, 'hFF), 0, 0, 'h100FF);
    lookup("R5 bound edge", va(0, 'h100), 0, 3, 0);
    lookup("R6 write denied", va(0, 'h10), 1, 4, 0);
    lookup("R4 invalid", va(1, 0), 0, 2, 0);
    lookup("R3 range", va(4, 0), 0, 1, 0);
    lookup("R3 range over valid entry", va(5, 0), 0, 1, 0);
    lookup("R7 wrap exec", va(2, 'h200), 2, 0, 'h00100);
    lookup("R6 reserved access", va(2, 0), 3, 4, 0);
    lookup("R6 write ok", va(3, 'h1F), 1, 0, 'h3001F);
    lookup("R6 exec denied", va(3, 0), 2, 4, 0);
  endtask

  task automatic t_priority;
    lookup("R4 beats bound+perm", va(1, 'hFFF), 3, 2, 0);
    lookup("R5 beats perm", va(0, 'h800), 1, 3, 0);
    lookup("R3 beats invalid", va(15, 'hFFF), 3, 1, 0);
  endtask

  task automatic t_base;
    set_table(14, 4);
    lookup("R2 wrapped index", va(2, 'h10), 0, 0, 'h10010);
    lookup("R2 start entry invalid", va(0, 0), 0, 2, 0);
    lookup("R2 seg3 to entry1", va(3, 0), 0, 2, 0);
    set_table(0, 4);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1; req_vaddr = va(0, 'h4); req_access = 0;
    cfg_we = 1; cfg_idx = 0; cfg_valid = 1; cfg_base = 'h40000;
    cfg_bound = 'h100; cfg_perm = 3'b001;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk("R9 old entry used", 32'(resp_paddr), 'h10004);
    lookup("R9 new entry next", va(0, 'h4), 0, 0, 'h40004);
    @(negedge clk);
    req_valid = 1; req_vaddr = va(3, 0); req_access = 1;
    tbl_size_we = 1; tbl_size_in = 2;
    @(negedge clk);
    req_valid = 0; tbl_size_we = 0;
    chk("R9 old size used", 32'(resp_fault), 0);
    lookup("R9 new size next", va(3, 0), 1, 1, 0);
    set_table(0, 4);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    resp_ready = 0;
    req_valid = 1; req_vaddr = va(0, 'h1); req_access = 0;
    @(negedge clk);
    chk("R8 first result", 32'(resp_paddr), 'h40001);
    req_vaddr = va(2, 'h5); req_access = 0;
    chk("R8 ready low", 32'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 held valid", 32'(resp_valid), 1);
    chk("R8 held paddr", 32'(resp_paddr), 'h40001);
    chk("R8 still blocked", 32'(req_ready), 0);
    resp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 second valid", 32'(resp_valid), 1);
    chk("R8 second paddr", 32'(resp_paddr), 'hFFF05);
    @(negedge clk);
    chk("R8 valid drops", 32'(resp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_base();
    t_same_cycle();
    t_backpressure();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule